// File: doc/BRIEF.md
# Pause Frame Receive Filter

This block sits on the receive path of an Ethernet MAC, after preamble removal, and inspects every incoming frame one byte per clock. It decides whether the frame is a MAC control pause request. The destination, the EtherType and the control opcode must all match for a frame to qualify. When a frame qualifies and ends with a good-frame indication, the block reports it with a one-cycle pulse and takes the 16-bit pause value from the frame.

A non-zero value stops the local transmitter for that many slot times. A zero value releases it at once. One slot is 64 byte clocks, which is 512 ns at gigabit rate. A later pause request replaces the one in progress.

A single enable selects asymmetric operation. With the enable low, pause requests are still detected and reported, but they never hold the transmitter. The byte clock is the block clock: one tick is one byte time.

Top module: `pause_rx_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `pause_active` and `pause_seen` are low.
- R2: The destination is bytes 0 to 5 of the frame, sent most significant byte of the 48-bit address first. It must equal either `ctrl_addr` or `station_addr`, otherwise the frame is rejected.
- R3: Bytes 12 (high) and 13 (low) must equal the programmable `type_value`, otherwise the frame is rejected.
- R4: Bytes 14 (high) and 15 (low) must equal 0x0001, otherwise the frame is rejected.
- R5: An accepted frame raises `pause_seen` for exactly one cycle, on the cycle after its end byte. A frame whose end byte carries `rx_good` low raises nothing and changes no pause state.
- R6: The pause value is bytes 16 (high) and 17 (low). A non-zero value Q makes `pause_active` high from the second clock edge after the end byte, for exactly 64*Q cycles.
- R7: A pause value of zero (XON) makes `pause_active` low from the second clock edge after the end byte, even in the middle of a pause.
- R8: A non-zero pause request that arrives during a pause reloads the countdown, so the pause lasts 64*Q cycles counted from the new request.
- R9: With `pause_honour_en` low, accepted frames still pulse `pause_seen` but never raise `pause_active`.
- R10: A frame whose end byte is at index 17 or lower is rejected. A frame whose end byte is at index 18 is accepted.
- R11: Cycles with `rx_valid` low inside a frame are skipped. They neither advance the byte index nor alter a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_sof | input | 1 | With `rx_valid`, marks byte 0 of a frame |
| rx_eof | input | 1 | With `rx_valid`, marks the last byte of a frame |
| rx_good | input | 1 | Frame-good flag, sampled with the end byte |
| rx_data | input | 8 | Received byte |
| ctrl_addr | input | 48 | Programmed control multicast address |
| station_addr | input | 48 | Station's own address |
| type_value | input | 16 | Expected EtherType for control frames |
| pause_honour_en | input | 1 | Allows accepted requests to pause the transmitter |
| pause_active | output | 1 | Transmitter must hold |
| pause_seen | output | 1 | One-cycle pulse per accepted pause frame |

## Verification
On every cycle, the assertions check these relations:
- `pause_seen` is a single-cycle pulse that follows a good end byte.
- `pause_active` only rises right after an honoured request.
- XON and XOFF requests drive `pause_active` low or high on the next edge.
- With honouring disabled, an idle transmitter stays released.

Only the bench scenarios can show the rest. These are the exact 64*Q length of a pause, its reload mid-count, and rejection on each of the three field comparisons. They also cover the minimum frame length boundary and byte gaps inside a frame, because each of these depends on whole frame contents over many cycles.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;

    localparam int QUANTA_W      = 16;
    localparam int DST_BYTES     = 6;
    localparam int TYPE_IDX      = 12;
    localparam int OPC_IDX       = 14;
    localparam int QUANTA_IDX    = 16;
    localparam int LAST_FIELD    = QUANTA_IDX + 1;
    localparam int MIN_END_IDX   = LAST_FIELD + 1;
    localparam int IDX_W         = $clog2(MIN_END_IDX + 1);
    localparam logic [15:0] PAUSE_OPCODE = 16'h0001;

    typedef struct packed {
        logic dst_ctrl;
        logic dst_sta;
        logic type_ok;
        logic op_ok;
    } match_t;

    typedef struct packed {
        logic                valid;
        logic [QUANTA_W-1:0] quanta;
    } pause_evt_t;

    function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [2:0] i);
        return a[8*(5-int'(i)) +: 8];
    endfunction

endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
    import pause_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_good,
    input  logic [7:0]       rx_data,
    input  logic [47:0]      ctrl_addr,
    input  logic [47:0]      station_addr,
    input  logic [15:0]      type_value,
    output pause_evt_t       evt
);
    localparam logic [IDX_W-1:0] I_DST_END = IDX_W'(DST_BYTES);
    localparam logic [IDX_W-1:0] I_TYPE_HI = IDX_W'(TYPE_IDX);
    localparam logic [IDX_W-1:0] I_TYPE_LO = IDX_W'(TYPE_IDX + 1);
    localparam logic [IDX_W-1:0] I_OPC_HI  = IDX_W'(OPC_IDX);
    localparam logic [IDX_W-1:0] I_OPC_LO  = IDX_W'(OPC_IDX + 1);
    localparam logic [IDX_W-1:0] I_Q_HI    = IDX_W'(QUANTA_IDX);
    localparam logic [IDX_W-1:0] I_Q_LO    = IDX_W'(QUANTA_IDX + 1);
    localparam logic [IDX_W-1:0] I_MIN_END = IDX_W'(MIN_END_IDX);
    localparam logic [IDX_W-1:0] I_SAT     = '1;

    logic                in_frame_q;
    logic [IDX_W-1:0]    idx_q, cur_idx;
    match_t              flags_q, base, hit;
    logic [QUANTA_W-1:0] quanta_q;
    logic                take, accept, fields_ok;

    always_comb begin
        cur_idx = rx_sof ? '0 : idx_q;
        base    = rx_sof ? match_t'('1) : flags_q;
        hit     = match_t'('1);
        if (cur_idx < I_DST_END) begin
            hit.dst_ctrl = (rx_data == addr_byte(ctrl_addr, cur_idx[2:0]));
            hit.dst_sta  = (rx_data == addr_byte(station_addr, cur_idx[2:0]));
        end
        if (cur_idx == I_TYPE_HI) hit.type_ok = (rx_data == type_value[15:8]);
        if (cur_idx == I_TYPE_LO) hit.type_ok = (rx_data == type_value[7:0]);
        if (cur_idx == I_OPC_HI)  hit.op_ok   = (rx_data == PAUSE_OPCODE[15:8]);
        if (cur_idx == I_OPC_LO)  hit.op_ok   = (rx_data == PAUSE_OPCODE[7:0]);
    end

    assign take      = rx_valid && (rx_sof || in_frame_q);
    assign fields_ok = (flags_q.dst_ctrl || flags_q.dst_sta) && flags_q.type_ok && flags_q.op_ok;
    assign accept    = take && rx_eof && rx_good && (cur_idx >= I_MIN_END) && fields_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
            flags_q    <= '0;
            quanta_q   <= '0;
            evt        <= '0;
        end else begin
            evt.valid  <= accept;
            evt.quanta <= quanta_q;
            if (take) begin
                flags_q    <= base & hit;
                idx_q      <= (cur_idx == I_SAT) ? cur_idx : cur_idx + 1'b1;
                in_frame_q <= !rx_eof;
                if (cur_idx == I_Q_HI) quanta_q[15:8] <= rx_data;
                if (cur_idx == I_Q_LO) quanta_q[7:0]  <= rx_data;
            end
        end
    end

endmodule

// File: rtl/pause_slot_timer.sv
module pause_slot_timer #(
    parameter int SLOT_TICKS = 64,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             active
);
    localparam int PRE_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/pause_rx_filter.sv
module pause_rx_filter
    import pause_rx_pkg::*;
#(
    parameter int SLOT_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_good,
    input  logic [7:0]  rx_data,
    input  logic [47:0] ctrl_addr,
    input  logic [47:0] station_addr,
    input  logic [15:0] type_value,
    input  logic        pause_honour_en,
    output logic        pause_active,
    output logic        pause_seen
);
    pause_evt_t          evt;
    logic [QUANTA_W-1:0] evt_quanta;

    pause_frame_parser u_parser (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_good      (rx_good),
        .rx_data      (rx_data),
        .ctrl_addr    (ctrl_addr),
        .station_addr (station_addr),
        .type_value   (type_value),
        .evt          (evt)
    );

    assign evt_quanta = evt.quanta;

    pause_slot_timer #(
        .SLOT_TICKS (SLOT_TICKS),
        .CNT_W      (QUANTA_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (evt.valid && pause_honour_en),
        .load_val (evt_quanta),
        .active   (pause_active)
    );

    assign pause_seen = evt.valid;

endmodule

// File: rtl/pause_rx_filter_chk.sv
module pause_rx_filter_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        rx_eof,
    input logic        rx_good,
    input logic        pause_honour_en,
    input logic        pause_seen,
    input logic        pause_active,
    input logic [15:0] evt_quanta
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!pause_active && !pause_seen));

    p_seen_after_good_end_r5: assert property (@(posedge clk) disable iff (rst)
        pause_seen |-> $past(rx_valid && rx_eof && rx_good));

    p_seen_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        pause_seen |=> !pause_seen);

    p_rise_needs_request_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pause_active) |-> $past(pause_seen && pause_honour_en));

    p_xoff_starts_r6: assert property (@(posedge clk) disable iff (rst)
        (pause_seen && pause_honour_en && evt_quanta != 16'd0) |=> pause_active);

    p_xon_cancels_r7: assert property (@(posedge clk) disable iff (rst)
        (pause_seen && pause_honour_en && evt_quanta == 16'd0) |=> !pause_active);

    p_ignore_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!pause_honour_en && !pause_active) |=> !pause_active);

endmodule

bind pause_rx_filter pause_rx_filter_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .rx_valid        (rx_valid),
    .rx_eof          (rx_eof),
    .rx_good         (rx_good),
    .pause_honour_en (pause_honour_en),
    .pause_seen      (pause_seen),
    .pause_active    (pause_active),
    .evt_quanta      (evt_quanta)
);

// File: tb/pause_rx_filter_tb_top.sv
`timescale 1ns/1ps
module pause_rx_filter_tb_top;

    localparam logic [47:0] CTRL_A = 48'h0180C2000001;
    localparam logic [47:0] STA_A  = 48'h00AABBCCDDEE;
    localparam logic [15:0] TYPE_D = 16'h8808;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_sof, rx_eof, rx_good;
    logic [7:0]  rx_data;
    logic [47:0] ctrl_addr, station_addr;
    logic [15:0] type_value;
    logic        pause_honour_en;
    logic        pause_active, pause_seen;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic seen_s;

    always #4 clk = ~clk;

    pause_rx_filter dut_i (
        .clk             (clk),
        .rst             (rst),
        .rx_valid        (rx_valid),
        .rx_sof          (rx_sof),
        .rx_eof          (rx_eof),
        .rx_good         (rx_good),
        .rx_data         (rx_data),
        .ctrl_addr       (ctrl_addr),
        .station_addr    (station_addr),
        .type_value      (type_value),
        .pause_honour_en (pause_honour_en),
        .pause_active    (pause_active),
        .pause_seen      (pause_seen)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_byte(input logic [47:0] dst, input logic [15:0] typ,
                                              input logic [15:0] op, input logic [15:0] q, input int i);
        if (i < 6)   return dst[8*(5-i) +: 8];
        if (i < 12)  return 8'h5A;
        if (i == 12) return typ[15:8];
        if (i == 13) return typ[7:0];
        if (i == 14) return op[15:8];
        if (i == 15) return op[7:0];
        if (i == 16) return q[15:8];
        if (i == 17) return q[7:0];
        return 8'(i);
    endfunction

    task automatic send_frame(input logic [47:0] dst, input logic [15:0] typ, input logic [15:0] op,
                              input logic [15:0] q, input bit good, input int len, input bit gap);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_good  = good;
            rx_data  = frame_byte(dst, typ, op, q, i);
            if (gap && i < len - 1) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'hFF;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
        seen_s = pause_seen;
    endtask

    task automatic pause_len(output int n);
        n = 0;
        @(negedge clk);
        while (pause_active && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 active in reset", int'(pause_active), 0);
        chk("R1 seen in reset", int'(pause_seen), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 active after reset", int'(pause_active), 0);
    endtask

    task automatic t_xoff_ctrl;
        int n;
        send_frame(CTRL_A, TYPE_D, 16'h0001, 16'd3, 1'b1, 64, 1'b0);
        chk("R5 seen pulse", int'(seen_s), 1);
        @(negedge clk);
        chk("R5 pulse one cycle", int'(pause_seen), 0);
        chk("R6 active started", int'(pause_active), 1);
        pause_len(n);
        chk("R6 length Q=3 control dst", n + 1, 192);
    endtask

    task automatic t_xoff_station;
        int n;
        send_frame(STA_A, TYPE_D, 16'h0001, 16'd1, 1'b1, 64, 1'b0);
        chk("R2 station dst accepted", int'(seen_s), 1);
        pause_len(n);
        chk("R6 length Q=1", n, 64);
    endtask

    task automatic t_reject(input string req, input logic [47:0] dst, input logic [15:0] typ,
                            input logic [15:0] op, input bit good, input int len);
        send_frame(dst, typ, op, 16'd7, good, len, 1'b0);
        chk({req, " no pulse"}, int'(seen_s), 0);
        @(negedge clk);
        chk({req, " no pause"}, int'(pause_active), 0);
    endtask

    task automatic t_prog_type;
        int n;
        type_value = 16'h88AA;
        t_reject("R3 old type after reprogram", CTRL_A, TYPE_D, 16'h0001, 1'b1, 64);
        send_frame(CTRL_A, 16'h88AA, 16'h0001, 16'd1, 1'b1, 64, 1'b0);
        chk("R3 programmed type accepted", int'(seen_s), 1);
        pause_len(n);
        chk("R3 programmed type pause length", n, 64);
        type_value = TYPE_D;
    endtask

    task automatic t_min_len;
        int n;
        t_reject("R10 end at index 17", CTRL_A, TYPE_D, 16'h0001, 1'b1, 18);
        send_frame(CTRL_A, TYPE_D, 16'h0001, 16'd1, 1'b1, 19, 1'b0);
        chk("R10 end at index 18 accepted", int'(seen_s), 1);
        pause_len(n);
        chk("R10 pause length", n, 64);
    endtask

    task automatic t_xon;
        send_frame(CTRL_A, TYPE_D, 16'h0001, 16'd100, 1'b1, 64, 1'b0);
        @(negedge clk);
        chk("R6 long pause active", int'(pause_active), 1);
        send_frame(STA_A, TYPE_D, 16'h0001, 16'd0, 1'b1, 64, 1'b0);
        chk("R7 XON seen", int'(seen_s), 1);
        chk("R7 still active on pulse cycle", int'(pause_active), 1);
        @(negedge clk);
        chk("R7 XON cancels", int'(pause_active), 0);
    endtask

    task automatic t_reload;
        int n;
        send_frame(CTRL_A, TYPE_D, 16'h0001, 16'd50, 1'b1, 64, 1'b0);
        send_frame(CTRL_A, TYPE_D, 16'h0001, 16'd2, 1'b1, 64, 1'b0);
        chk("R8 reload seen", int'(seen_s), 1);
        pause_len(n);
        chk("R8 reloaded length", n, 128);
    endtask

    task automatic t_honour_off;
        int hi = 0;
        pause_honour_en = 1'b0;
        send_frame(CTRL_A, TYPE_D, 16'h0001, 16'd5, 1'b1, 64, 1'b0);
        chk("R9 seen while disabled", int'(seen_s), 1);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pause_active) hi++;
        end
        chk("R9 no pause while disabled", hi, 0);
        pause_honour_en = 1'b1;
    endtask

    task automatic t_gaps;
        int n;
        send_frame(STA_A, TYPE_D, 16'h0001, 16'd2, 1'b1, 64, 1'b1);
        chk("R11 gapped frame seen", int'(seen_s), 1);
        pause_len(n);
        chk("R11 gapped frame length", n, 128);
    endtask

    initial begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; rx_data = 8'h00;
        ctrl_addr = CTRL_A; station_addr = STA_A; type_value = TYPE_D;
        pause_honour_en = 1'b1; seen_s = 1'b0;
        t_reset();
        t_xoff_ctrl();
        t_xoff_station();
        t_reject("R2 wrong dst", 48'h0180C2000002, TYPE_D, 16'h0001, 1'b1, 64);
        t_reject("R3 wrong type", CTRL_A, 16'h0800, 16'h0001, 1'b1, 64);
        t_prog_type();
        t_reject("R4 wrong opcode", CTRL_A, TYPE_D, 16'h0002, 1'b1, 64);
        t_reject("R5 bad frame flag", CTRL_A, TYPE_D, 16'h0001, 1'b0, 64);
        t_min_len();
        t_xon();
        t_reload();
        t_honour_off();
        t_gaps();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule